// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block sits between a PCI host bridge and system memory. It turns each inbound DMA address into a system physical address, and it reports a page mask or a fault along with it. Software programs a set of windows through a small register port. Each window has an enable bit, a mode bit, a base, a size mask and a translated base.

A window in direct mode relocates the address arithmetically. A window in scatter-gather mode builds the address of a page table entry (PTE) and reads it over a memory read port, then forms the result from the page number in that entry.

Addresses above 4 GB are treated as dual-address-cycle traffic. They are served by two paths: a flat identity window for one 1 TB range, and the last window acting as a 64-bit scatter-gather window. Only one translation is in flight at a time.

Top module: `pci_dma_xlate`

## Requirements
- R1: The register index `csr_sel[3:2]` selects the kind: 0 = window base, 1 = window size mask, 2 = translated base, 3 = control. `csr_sel[1:0]` selects the window and is ignored for control. Write masks are as follows:
  - Bases of windows 0-2 keep bits 31:20 and 1:0.
  - The base of window 3 keeps bit 39, bits 31:20 and bit 0, and always reads bit 1 as 1.
  - Size masks keep bits 31:20.
  - Translated bases keep bits 34:10.
  - Control keeps bits 6:5.
  
  After reset everything reads 0 except the base of window 3, which reads 2.
- R2: A 32-bit address hits a window only if the window's base bit 0 is set. It must also satisfy the match rule: the address, with the bits under (size mask OR 0xFFFFF) cleared, equals the base bits 31:20 with zeros below.
- R3: A hit on a window whose base bit 1 is clear gives an output address of (translated base AND NOT extmask) OR (address AND extmask), with extmask = size mask OR 0xFFFFF. `rsp_mask` equals extmask.
- R4: A hit on a window whose base bit 1 is set issues one memory read. Its address is (translated base AND NOT (size mask >> 10)) OR ((address AND (size mask OR 0xFE000)) >> 10). The read address is held while `mem_req_valid` waits for `mem_req_ready`.
- R5: A returned PTE with bit 0 set gives the output address {PTE[21:1], address[12:0]} and `rsp_mask` = 0x1FFF. A PTE with bit 0 clear gives a fault.
- R6: For 32-bit addresses, windows are tried in order 0, 1, 2, and the lowest-numbered hit wins. Window 3 is tried last, and only when its base bit 39 is clear.
- R7: With control bit 5 set, 32-bit addresses from 0x80000 to 0xFFFFF match no window.
- R8: With control bit 6 set, addresses from 0x100_0000_0000 to 0x1FF_FFFF_FFFF map to their own low 35 bits, with `rsp_mask` = 0x7_FFFF_FFFF. With the bit clear they fault.
- R9: Addresses from 0x800_0000_0000 to 0xFFF_FFFF_FFFF are handled only when window 3 has bits 39 and 0 set. Such an address fetches a PTE at (translated base AND 0x7FFC00000) OR ((address AND 0xFFFFE000) >> 10).
- R10: A request that no path accepts returns `rsp_fault` = 1 with `rsp_addr` and `rsp_mask` both 0.
- R11: `req_ready` is high only when no translation is pending. A translation without a fetch responds (`rsp_valid` for one cycle) in the cycle after acceptance. A fetched one responds in the cycle after `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 4 | Register index {kind, window} |
| csr_wdata | input | 40 | Register write data |
| csr_rdata | output | 40 | Contents of the selected register |
| req_valid | input | 1 | DMA address request valid |
| req_ready | output | 1 | Translator can accept a request |
| req_addr | input | 44 | Inbound DMA address |
| mem_req_valid | output | 1 | PTE read request valid |
| mem_req_ready | input | 1 | Memory accepts the PTE read |
| mem_req_addr | output | 35 | PTE physical address |
| mem_rsp_valid | input | 1 | PTE read data valid |
| mem_rsp_data | input | 64 | PTE read data |
| rsp_valid | output | 1 | Translation result valid, one cycle |
| rsp_addr | output | 35 | Translated physical address |
| rsp_mask | output | 35 | Page offset mask of the result |
| rsp_fault | output | 1 | No permission: translation failed |

## Verification
Three cases take a shifted mask or range bit, so an off-by-one in those bounds shows up directly:
- The hole is probed at 0x7FFFF, 0x80000 and 0x90000.
- The flat window is probed with its enable bit both clear and set.
- The 64-bit window is probed both inside and just below its range.

Overlapping windows 0 and 2 expose a reversed priority, which would return the higher window's relocation. Window 3 is probed with bit 39 toggled; a design that ignores that bit would keep translating 32-bit addresses through it. Scatter-gather cases compare the exact PTE read address, so a wrong shift or mask term lands on a different address. An invalid PTE must come back as a zeroed fault.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    localparam int DMA_W  = 44;   // inbound DMA address width
    localparam int PA_W   = 35;   // system physical address width
    localparam int CSR_DW = 40;   // register data width
    localparam int PTE_DW = 64;   // memory read data width

    localparam logic [PA_W-1:0] SG_PAGE_MASK = 35'h0_0000_1FFF;
    localparam logic [PA_W-1:0] FLAT_MASK    = 35'h7_FFFF_FFFF;
    localparam logic [PA_W-1:0] DAC_TB_KEEP  = 35'h7_FFC0_0000;

    typedef enum logic [1:0] {
        SEL_BASE  = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_TBASE = 2'd2,
        SEL_CTL   = 2'd3
    } sel_kind_e;

    // Only the writable bits of each window are stored.
    typedef struct packed {
        logic        dac;      // base bit 39
        logic [11:0] base_hi;  // base bits 31:20
        logic        sg;       // base bit 1
        logic        en;       // base bit 0
        logic [11:0] mask_hi;  // size mask bits 31:20
        logic [24:0] tb;       // translated base bits 34:10
    } win_cfg_t;

    typedef struct packed {
        logic            fault;
        logic            fetch;   // addr holds a PTE address
        logic [PA_W-1:0] addr;
        logic [PA_W-1:0] mask;
    } xres_t;

    typedef enum logic [1:0] {
        F_IDLE  = 2'd0,
        F_ISSUE = 2'd1,
        F_WAIT  = 2'd2
    } fstate_e;

    function automatic logic [31:0] ext_mask(input logic [11:0] mhi);
        return {mhi, 20'hF_FFFF};
    endfunction

    function automatic logic [PA_W-1:0] tb_full(input logic [24:0] tb);
        return {tb, 10'b0};
    endfunction

endpackage

// File: rtl/dmx_csr.sv
module dmx_csr
    import dmx_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int IDX_W   = $clog2(NUM_WIN),
    parameter int SEL_W   = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [CSR_DW-1:0] wdata,
    output logic [CSR_DW-1:0] rdata,
    output win_cfg_t          cfg [NUM_WIN],
    output logic              ctl_hole,
    output logic              ctl_flat
);

    localparam int LAST = NUM_WIN - 1;

    sel_kind_e        kind;
    logic [IDX_W-1:0] idx;
    assign kind = sel_kind_e'(sel[SEL_W-1:IDX_W]);
    assign idx  = sel[IDX_W-1:0];

    wire unused_wdata = ^{wdata[38:35], wdata[9:7], wdata[4:2]};

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic hit_idx;
        assign hit_idx = we && (idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[g]    <= '0;
                cfg[g].sg <= (g == LAST);
            end else if (hit_idx) begin
                case (kind)
                    SEL_BASE: begin
                        cfg[g].base_hi <= wdata[31:20];
                        cfg[g].en      <= wdata[0];
                        if (g == LAST) begin
                            cfg[g].dac <= wdata[39];
                            cfg[g].sg  <= 1'b1;
                        end else begin
                            cfg[g].dac <= 1'b0;
                            cfg[g].sg  <= wdata[1];
                        end
                    end
                    SEL_MASK:  cfg[g].mask_hi <= wdata[31:20];
                    SEL_TBASE: cfg[g].tb      <= wdata[34:10];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_hole <= 1'b0;
            ctl_flat <= 1'b0;
        end else if (we && kind == SEL_CTL) begin
            ctl_hole <= wdata[5];
            ctl_flat <= wdata[6];
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (idx == IDX_W'(i)) begin
                case (kind)
                    SEL_BASE:  rdata = {cfg[i].dac, 7'b0, cfg[i].base_hi, 18'b0,
                                        cfg[i].sg, cfg[i].en};
                    SEL_MASK:  rdata = {8'b0, cfg[i].mask_hi, 20'b0};
                    SEL_TBASE: rdata = {5'b0, cfg[i].tb, 10'b0};
                    default:   rdata = {33'b0, ctl_flat, ctl_hole, 5'b0};
                endcase
            end
        end
    end

    // R1: a base write to the last window keeps its enable and forces the mode bit
    p_last_sg_forced_r1: assert property (@(posedge clk) disable iff (rst)
        (we && kind == SEL_BASE && idx == IDX_W'(LAST))
        |=> (cfg[LAST].sg && cfg[LAST].en == $past(wdata[0])));

endmodule

// File: rtl/dmx_decode.sv
module dmx_decode
    import dmx_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  win_cfg_t           cfg [NUM_WIN],
    input  logic               ctl_hole,
    input  logic               ctl_flat,
    input  logic [DMA_W-1:0]   addr,
    output xres_t              res,
    output logic [NUM_WIN-1:0] grant
);

    localparam int LAST = NUM_WIN - 1;

    logic [31:0]     a32;
    logic            is_sac;
    logic            in_hole;
    logic            in_flat;
    logic            in_dac;
    logic [PA_W-1:0] dac_pte;

    assign a32     = addr[31:0];
    assign is_sac  = (addr[DMA_W-1:32] == '0);
    assign in_hole = ctl_hole && (a32[31:20] == 12'h0) && a32[19];
    assign in_flat = (addr[43:40] == 4'h1);
    assign in_dac  = addr[43];
    assign dac_pte = (tb_full(cfg[LAST].tb) & DAC_TB_KEEP)
                   | {13'b0, a32[31:13], 3'b0};

    logic  [NUM_WIN-1:0] hit;
    xres_t               wres [NUM_WIN];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
        logic [31:0]     wext;
        logic [PA_W-1:0] tbf;
        logic [31:0]     sg_off;

        assign wext   = ext_mask(cfg[g].mask_hi);
        assign tbf    = tb_full(cfg[g].tb);
        assign sg_off = (a32 & {cfg[g].mask_hi, 20'hF_E000}) >> 10;
        assign hit[g] = cfg[g].en && !cfg[g].dac
                     && ((a32 & ~wext) == {cfg[g].base_hi, 20'h0});

        always_comb begin
            wres[g].fault = 1'b0;
            wres[g].fetch = cfg[g].sg;
            if (cfg[g].sg) begin
                wres[g].addr = (tbf & ~{13'b0, cfg[g].mask_hi, 10'b0})
                             | {3'b0, sg_off};
                wres[g].mask = '0;
            end else begin
                wres[g].addr = (tbf & ~{3'b0, wext}) | {3'b0, a32 & wext};
                wres[g].mask = {3'b0, wext};
            end
        end
    end

    always_comb begin
        res   = '{fault: 1'b1, fetch: 1'b0, addr: '0, mask: '0};
        grant = '0;
        if (is_sac) begin
            if (!in_hole) begin
                for (int i = LAST; i >= 0; i--) begin
                    if (hit[i]) begin
                        res   = wres[i];
                        grant = NUM_WIN'(1) << i;
                    end
                end
            end
        end else if (in_flat && ctl_flat) begin
            res = '{fault: 1'b0, fetch: 1'b0, addr: addr[PA_W-1:0], mask: FLAT_MASK};
        end else if (in_dac && cfg[LAST].dac && cfg[LAST].en) begin
            res = '{fault: 1'b0, fetch: 1'b1, addr: dac_pte, mask: '0};
        end
    end

endmodule

// File: rtl/dmx_pte_fetch.sv
module dmx_pte_fetch
    import dmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PA_W-1:0]   start_addr,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    output logic              done
);

    fstate_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= F_IDLE;
            mem_req_addr <= '0;
        end else begin
            case (state)
                F_IDLE: if (start) begin
                    state        <= F_ISSUE;
                    mem_req_addr <= start_addr;
                end
                F_ISSUE: if (mem_req_ready) state <= F_WAIT;
                F_WAIT:  if (mem_rsp_valid) state <= F_IDLE;
                default: state <= F_IDLE;
            endcase
        end
    end

    assign busy          = (state != F_IDLE);
    assign mem_req_valid = (state == F_ISSUE);
    assign done          = (state == F_WAIT) && mem_rsp_valid;

    // R4: an unaccepted PTE read stays up with the same address
    p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R11: a new fetch is started only from idle
    p_start_idle_r11: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

endmodule

// File: rtl/pci_dma_xlate.sv
module pci_dma_xlate
    import dmx_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int IDX_W   = $clog2(NUM_WIN),
    parameter int SEL_W   = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_we,
    input  logic [SEL_W-1:0]  csr_sel,
    input  logic [CSR_DW-1:0] csr_wdata,
    output logic [CSR_DW-1:0] csr_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DMA_W-1:0]  req_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_DW-1:0] mem_rsp_data,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_addr,
    output logic [PA_W-1:0]   rsp_mask,
    output logic              rsp_fault
);

    win_cfg_t           cfg [NUM_WIN];
    logic               ctl_hole, ctl_flat;
    xres_t              dres;
    logic [NUM_WIN-1:0] grant;
    logic               busy, done, accept;
    logic [12:0]        off_q;

    wire unused_pte_hi = ^mem_rsp_data[PTE_DW-1:22];

    dmx_csr #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_csr (
        .clk(clk), .rst(rst), .we(csr_we), .sel(csr_sel), .wdata(csr_wdata),
        .rdata(csr_rdata), .cfg(cfg), .ctl_hole(ctl_hole), .ctl_flat(ctl_flat)
    );

    dmx_decode #(.NUM_WIN(NUM_WIN)) u_dec (
        .cfg(cfg), .ctl_hole(ctl_hole), .ctl_flat(ctl_flat),
        .addr(req_addr), .res(dres), .grant(grant)
    );

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;

    dmx_pte_fetch u_fetch (
        .clk(clk), .rst(rst), .start(accept && dres.fetch), .start_addr(dres.addr),
        .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .done(done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_addr  <= '0;
            rsp_mask  <= '0;
            off_q     <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) off_q <= req_addr[12:0];
            if (accept && !dres.fetch) begin
                rsp_valid <= 1'b1;
                rsp_fault <= dres.fault;
                rsp_addr  <= dres.addr;
                rsp_mask  <= dres.mask;
            end else if (done) begin
                rsp_valid <= 1'b1;
                rsp_fault <= !mem_rsp_data[0];
                rsp_addr  <= mem_rsp_data[0] ? {1'b0, mem_rsp_data[21:1], off_q} : '0;
                rsp_mask  <= mem_rsp_data[0] ? SG_PAGE_MASK : '0;
            end
        end
    end

    // R11: no new request is taken while a PTE read is outstanding
    p_ready_busy_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    // R11: a translation without fetch answers on the next cycle
    p_direct_latency_r11: assert property (@(posedge clk) disable iff (rst)
        (accept && !dres.fetch) |=> rsp_valid);

    // R10: a fault carries no address and no mask
    p_fault_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_addr == '0 && rsp_mask == '0));

    // R6: at most one window is selected
    p_one_grant_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

endmodule

// File: tb/test_pci_dma_xlate.sv
module test_pci_dma_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_we = 1'b0;
    logic [3:0]  csr_sel = '0;
    logic [39:0] csr_wdata = '0;
    logic [39:0] csr_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [43:0] req_addr = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [34:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [34:0] rsp_addr;
    logic [34:0] rsp_mask;
    logic        rsp_fault;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic        r_fault, r_fetch;
    logic [34:0] r_addr, r_mask, r_faddr;
    int          r_lat;

    always #5 clk = ~clk;

    pci_dma_xlate i_pci_dma_xlate (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_mask(rsp_mask),
        .rsp_fault(rsp_fault)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic csr_wr(input logic [3:0] s, input logic [39:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_sel = s; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_chk(input string tag, input logic [3:0] s, input logic [39:0] exp);
        @(negedge clk);
        csr_sel = s;
        #1;
        chk(tag, csr_rdata, exp);
    endtask

    task automatic xlate(input logic [43:0] a, input logic [63:0] pte);
        bit got = 0;
        r_fetch = 0; r_lat = 0; r_faddr = '0;
        r_fault = 0; r_addr = '0; r_mask = '0;
        @(negedge clk);
        chk("R11 ready when idle", req_ready, 1);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 0; n < 40 && !got; n++) begin
            if (rsp_valid) begin
                r_addr = rsp_addr; r_mask = rsp_mask; r_fault = rsp_fault;
                r_lat = n; got = 1;
            end else if (mem_req_valid && !r_fetch) begin
                r_fetch = 1; r_faddr = mem_req_addr;
                chk("R11 ready low during fetch", req_ready, 0);
                @(negedge clk);
                chk("R4 read request held", {mem_req_valid, mem_req_addr}, {1'b1, r_faddr});
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                chk("R11 no response before data", rsp_valid, 0);
                mem_rsp_valid = 1'b1; mem_rsp_data = pte;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        if (!got) chk("R11 response arrives", 0, 1);
    endtask

    task automatic expect_rsp(input string tag, input logic f, input logic [34:0] a,
                              input logic [34:0] m, input logic fe, input logic [34:0] fa);
        chk({tag, " fault"}, r_fault, f);
        chk({tag, " addr"}, r_addr, a);
        chk({tag, " mask"}, r_mask, m);
        chk({tag, " fetch"}, r_fetch, fe);
        if (fe) chk({tag, " pte address"}, r_faddr, fa);
        else    chk({tag, " latency"}, r_lat, 0);
    endtask

    task automatic t_reset;
        csr_chk("R1 reset base0", 4'h0, 40'h0);
        csr_chk("R1 reset base3", 4'h3, 40'h2);
        csr_chk("R1 reset ctl", 4'hC, 40'h0);
        chk("R11 reset no response", rsp_valid, 0);
    endtask

    task automatic t_write_masks;
        csr_wr(4'h0, '1); csr_chk("R1 base0 mask", 4'h0, 40'h00_FFF0_0003);
        csr_wr(4'h3, '1); csr_chk("R1 base3 mask", 4'h3, 40'h80_FFF0_0003);
        csr_wr(4'h3, 40'h0); csr_chk("R1 base3 bit1 forced", 4'h3, 40'h2);
        csr_wr(4'h5, '1); csr_chk("R1 size mask", 4'h5, 40'h00_FFF0_0000);
        csr_wr(4'hA, '1); csr_chk("R1 translated base", 4'hA, 40'h07_FFFF_FC00);
        csr_wr(4'hD, '1); csr_chk("R1 control", 4'hC, 40'h60);
        csr_wr(4'hC, 40'h0);
        csr_wr(4'h0, 40'h0); csr_wr(4'h5, 40'h0); csr_wr(4'hA, 40'h0);
    endtask

    task automatic t_direct;
        csr_wr(4'h0, 40'h4000_0001);
        csr_wr(4'h4, 40'h0FF0_0000);
        csr_wr(4'h8, 40'h2_0000_0000);
        xlate(44'h4123_4567, 0);
        expect_rsp("R3 direct hit", 0, 35'h2_0123_4567, 35'h0FFF_FFFF, 0, 0);
        xlate(44'h5000_0000, 0);
        expect_rsp("R10 no window", 1, 0, 0, 0, 0);
        csr_wr(4'h0, 40'h4000_0000);
        xlate(44'h4123_4567, 0);
        expect_rsp("R2 disabled window", 1, 0, 0, 0, 0);
        csr_wr(4'h0, 40'h4000_0001);
    endtask

    task automatic t_sg;
        csr_wr(4'h1, 40'h8000_0003);
        csr_wr(4'h5, 40'h0010_0000);
        csr_wr(4'h9, 40'h1_0000_0000);
        xlate(44'h8012_3456, 64'h2468B);
        expect_rsp("R5 valid pte", 0, 35'h2468_B456, 35'h1FFF, 1, 35'h1_0000_0488);
        xlate(44'h8012_3456, 64'h2468A);
        expect_rsp("R5 invalid pte", 1, 0, 0, 1, 35'h1_0000_0488);
    endtask

    task automatic t_priority;
        csr_wr(4'h2, 40'h4000_0001);
        csr_wr(4'h6, 40'h0);
        csr_wr(4'hA, 40'h3_0000_0000);
        xlate(44'h4000_0010, 0);
        expect_rsp("R6 window0 wins", 0, 35'h2_0000_0010, 35'h0FFF_FFFF, 0, 0);
        csr_wr(4'h0, 40'h0);
        xlate(44'h4000_0010, 0);
        expect_rsp("R6 window2 next", 0, 35'h3_0000_0010, 35'hF_FFFF, 0, 0);
        csr_wr(4'h3, 40'hC000_0001);
        csr_wr(4'h7, 40'h0);
        csr_wr(4'hB, 40'h40_0000);
        xlate(44'hC001_2345, 64'hEEF);
        expect_rsp("R6 window3 last", 0, 35'hEE_E345, 35'h1FFF, 1, 35'h40_0048);
        csr_wr(4'h3, 40'h80_C000_0001);
        xlate(44'hC001_2345, 64'hEEF);
        expect_rsp("R6 window3 excluded by bit39", 1, 0, 0, 0, 0);
    endtask

    task automatic t_hole;
        csr_wr(4'h0, 40'h1);
        csr_wr(4'h4, 40'h0);
        csr_wr(4'h8, 40'h5_0000_0000);
        xlate(44'h9_0000, 0);
        expect_rsp("R7 hole off", 0, 35'h5_0009_0000, 35'hF_FFFF, 0, 0);
        csr_wr(4'hC, 40'h20);
        xlate(44'h9_0000, 0);
        expect_rsp("R7 hole inside", 1, 0, 0, 0, 0);
        xlate(44'h8_0000, 0);
        expect_rsp("R7 hole low edge", 1, 0, 0, 0, 0);
        xlate(44'h7_FFFF, 0);
        expect_rsp("R7 below hole", 0, 35'h5_0007_FFFF, 35'hF_FFFF, 0, 0);
    endtask

    task automatic t_flat;
        csr_wr(4'hC, 40'h0);
        xlate(44'h123_4567_89AB, 0);
        expect_rsp("R8 flat disabled", 1, 0, 0, 0, 0);
        csr_wr(4'hC, 40'h60);
        xlate(44'h123_4567_89AB, 0);
        expect_rsp("R8 flat identity", 0, 35'h3_4567_89AB, 35'h7_FFFF_FFFF, 0, 0);
    endtask

    task automatic t_dac;
        csr_wr(4'h3, 40'h80_0000_0001);
        csr_wr(4'hB, 40'h1_2340_0000);
        xlate(44'h800_ABCD_E123, 64'h3579B);
        expect_rsp("R9 dac window", 0, 35'h3579_A123, 35'h1FFF, 1, 35'h1_236A_F378);
        xlate(44'h7FF_FFFF_FFFF, 0);
        expect_rsp("R9 R10 outside ranges", 1, 0, 0, 0, 0);
        csr_wr(4'h3, 40'h80_0000_0000);
        xlate(44'h800_ABCD_E123, 0);
        expect_rsp("R9 dac disabled", 1, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_write_masks;
        t_direct;
        t_sg;
        t_priority;
        t_hole;
        t_flat;
        t_dac;
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R11 watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule